// File: doc/BRIEF.md
# Weighted Multi-Exposure Radiance Merger

This block fuses one pixel position seen at several exposure times into a single log-radiance value. Every cycle it may accept `P` co-located pixel codes, one per exposure. Each code picks a log-response value from a camera response table that is loaded from outside. The exposure's log exposure-time constant is subtracted from that value. The result is scaled by a triangular confidence weight, which is largest at mid-scale and falls to zero at both ends of the code range. The scaled terms are summed, the weights are summed, and one shared divider forms the weighted mean.

All arithmetic is fixed-point and signed. The response table and the log exposure-time constants share one numeric format, and the output keeps that format. Software or a calibration engine fills the response table through a write port. The per-exposure constants are updated frame by frame through a register write port. The pipeline accepts one pixel position per clock and has a fixed latency of five cycles. When every exposure sits at an end of the code range, no weight is available. The block then returns the term of the middle exposure on its own and does not divide.

Top module: `hdrm_merge`

## Requirements
- R1: While `rst` is high and in the cycles after it is released, `out_valid` stays low until a pixel is accepted after reset; pixels presented during reset are discarded.
- R2: A pixel position is accepted on each rising edge at which `in_valid` is high. Its result appears with `out_valid` high exactly 5 rising edges later, counting the accepting edge as the first. Back-to-back inputs give back-to-back outputs in the same order.
- R3: The weight of a code z is z − ZMIN when 2·z ≤ ZMIN + ZMAX, and ZMAX − z otherwise. With the defaults ZMIN = 0 and ZMAX = 1023, codes 0 and 1023 weigh 0 and codes 511 and 512 both weigh 511.
- R4: `out_lrad` equals Σ w(zᵢ)·(g(zᵢ) − Lᵢ) divided by Σ w(zᵢ), truncated toward zero, as a signed two's-complement value. Here zᵢ is `pix_in[i*PIX_W +: PIX_W]`, g is the response table and Lᵢ is the log exposure-time constant of exposure i.
- R5: A write with `lut_we` high stores `lut_wdata` at entry `lut_addr` of the response table. Every exposure uses that entry from the next accepted pixel on.
- R6: A write with `lexp_we` high stores `lexp_wdata` as the constant of exposure `lexp_sel`. That constant applies to pixels accepted from the next cycle on. All constants reset to 0.
- R7: When every weight is zero, `out_lrad` is g(z_m) − L_m, where m = P/2 (integer division), which is exposure 1 for P = 2 and for P = 3.
- R8: Cycles with `in_valid` low produce no output, whatever `pix_in` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lut_we | input | 1 | Response table write enable |
| lut_addr | input | PIX_W | Response table entry to write |
| lut_wdata | input | G_W | Signed log-response value to store |
| lexp_we | input | 1 | Log exposure-time constant write enable |
| lexp_sel | input | SEL_W | Exposure index of the constant being written |
| lexp_wdata | input | G_W | Signed log exposure-time constant |
| in_valid | input | 1 | Pixel position present this cycle |
| pix_in | input | P*PIX_W | Pixel codes, exposure i in bits i*PIX_W upward |
| out_valid | output | 1 | Merged value present |
| out_lrad | output | G_W+1 | Signed merged log radiance |

## Verification
Three unrelated exposure constants and a linear response table feed mixed mid-range pixel sets, dark sets and bright sets. A wrong lane-to-constant pairing or a wrong sign would shift the quotient in these cases. Codes at 0, 511, 512 and 1023 probe both arms of the weight hat and the midpoint. Sets with every code saturated, in two different arrangements, show that the fallback takes the middle exposure and no other. A long unbroken stream, a stream with gaps carrying garbage codes, and reloads of one table entry and one constant show the cycle timing, the order of results, and when a new calibration value starts to apply.

// File: rtl/hdrm_pkg.sv
package hdrm_pkg;
  // Triangular confidence weight: rises from the low code, falls toward the high code.
  function automatic int unsigned hat_weight(input int unsigned z,
                                             input int unsigned zlo,
                                             input int unsigned zhi);
    if (2 * z <= zlo + zhi) return z - zlo;
    return zhi - z;
  endfunction
endpackage

// File: rtl/hdrm_resp_lut.sv
module hdrm_resp_lut #(
  parameter int PIX_W = 10,
  parameter int G_W   = 16
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [PIX_W-1:0]        wr_addr,
  input  logic signed [G_W-1:0]   wr_data,
  input  logic [PIX_W-1:0]        rd_addr,
  output logic signed [G_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << PIX_W;

  logic signed [G_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/hdrm_lane.sv
module hdrm_lane
  import hdrm_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int G_W   = 16,
  parameter int ZMIN  = 0,
  parameter int ZMAX  = 1023,
  parameter int W_W   = 9,
  parameter int DIFF_W = G_W + 1,
  parameter int PROD_W = DIFF_W + W_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      lut_we,
  input  logic [PIX_W-1:0]          lut_addr,
  input  logic signed [G_W-1:0]     lut_wdata,
  input  logic [PIX_W-1:0]          pix_i,
  input  logic signed [G_W-1:0]     lexp_i,
  output logic [W_W-1:0]            w_o,
  output logic signed [DIFF_W-1:0]  diff_o,
  output logic signed [PROD_W-1:0]  prod_o
);
  // stage 1: table read and weight
  logic signed [G_W-1:0] g_s1;
  logic [W_W-1:0]        w_s1;
  // stage 2: subtract exposure constant
  logic signed [DIFF_W-1:0] diff_s2;
  logic [W_W-1:0]           w_s2;

  hdrm_resp_lut #(.PIX_W(PIX_W), .G_W(G_W)) u_lut (
    .clk     (clk),
    .wr_en   (lut_we),
    .wr_addr (lut_addr),
    .wr_data (lut_wdata),
    .rd_addr (pix_i),
    .rd_data (g_s1)
  );

  always_ff @(posedge clk) begin
    w_s1 <= W_W'(hat_weight(int'(pix_i), ZMIN, ZMAX));
  end

  always_ff @(posedge clk) begin
    diff_s2 <= DIFF_W'(g_s1) - DIFF_W'(lexp_i);
    w_s2    <= w_s1;
  end

  always_ff @(posedge clk) begin
    prod_o <= $signed({1'b0, w_s2}) * diff_s2;
    diff_o <= diff_s2;
    w_o    <= w_s2;
  end

  // Saturated codes carry no confidence one cycle later.
  assert_sat_zero_weight_R3: assert property (@(posedge clk) disable iff (rst)
    (pix_i == PIX_W'(ZMIN) || pix_i == PIX_W'(ZMAX)) |=> (w_s1 == '0));
endmodule

// File: rtl/hdrm_div.sv
module hdrm_div #(
  parameter int SUM_W  = 30,
  parameter int DEN_W  = 12,
  parameter int DIFF_W = 17
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      v_i,
  input  logic signed [SUM_W-1:0]   num_i,
  input  logic [DEN_W-1:0]          den_i,
  input  logic signed [DIFF_W-1:0]  fb_i,
  output logic signed [DIFF_W-1:0]  q_o
);
  logic signed [SUM_W-1:0] divisor;

  always_comb divisor = {{(SUM_W-DEN_W){1'b0}}, den_i};

  always_ff @(posedge clk) begin
    if (den_i == '0) q_o <= fb_i;
    else             q_o <= DIFF_W'(num_i / divisor);
  end

  // No weight at all: the middle exposure's term passes through unchanged.
  assert_fallback_bypass_R7: assert property (@(posedge clk) disable iff (rst)
    (v_i && den_i == '0) |=> (q_o == $past(fb_i)));
endmodule

// File: rtl/hdrm_merge.sv
module hdrm_merge #(
  parameter int P     = 3,
  parameter int PIX_W = 10,
  parameter int G_W   = 16,
  parameter int ZMIN  = 0,
  parameter int ZMAX  = 1023,
  localparam int SEL_W  = (P > 1) ? $clog2(P) : 1,
  localparam int HALF   = (ZMAX - ZMIN) / 2,
  localparam int W_W    = $clog2(HALF + 1),
  localparam int DIFF_W = G_W + 1,
  localparam int PROD_W = DIFF_W + W_W + 1,
  localparam int SUM_W  = PROD_W + $clog2(P) + 1,
  localparam int DEN_W  = W_W + $clog2(P) + 1,
  localparam int MID    = P / 2,
  localparam int LAT    = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        lut_we,
  input  logic [PIX_W-1:0]            lut_addr,
  input  logic signed [G_W-1:0]       lut_wdata,
  input  logic                        lexp_we,
  input  logic [SEL_W-1:0]            lexp_sel,
  input  logic signed [G_W-1:0]       lexp_wdata,
  input  logic                        in_valid,
  input  logic [P*PIX_W-1:0]          pix_in,
  output logic                        out_valid,
  output logic signed [DIFF_W-1:0]    out_lrad
);
  logic signed [G_W-1:0]    lexp_q [P];
  logic [W_W-1:0]           w_l    [P];
  logic signed [DIFF_W-1:0] diff_l [P];
  logic signed [PROD_W-1:0] prod_l [P];

  logic [LAT-1:0]           vpipe;
  logic signed [SUM_W-1:0]  num_c, num_s4;
  logic [DEN_W-1:0]         den_c, den_s4;
  logic signed [DIFF_W-1:0] fb_s4;

  // Valid tracking through the five stages.
  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], in_valid};
  end
  assign out_valid = vpipe[LAT-1];

  for (genvar i = 0; i < P; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lexp_q[i] <= '0;
      else if (lexp_we && lexp_sel == SEL_W'(i)) lexp_q[i] <= lexp_wdata;
    end

    hdrm_lane #(
      .PIX_W(PIX_W), .G_W(G_W), .ZMIN(ZMIN), .ZMAX(ZMAX),
      .W_W(W_W), .DIFF_W(DIFF_W), .PROD_W(PROD_W)
    ) u_lane (
      .clk       (clk),
      .rst       (rst),
      .lut_we    (lut_we),
      .lut_addr  (lut_addr),
      .lut_wdata (lut_wdata),
      .pix_i     (pix_in[i*PIX_W +: PIX_W]),
      .lexp_i    (lexp_q[i]),
      .w_o       (w_l[i]),
      .diff_o    (diff_l[i]),
      .prod_o    (prod_l[i])
    );

    assert_lexp_load_R6: assert property (@(posedge clk) disable iff (rst)
      (lexp_we && lexp_sel == SEL_W'(i)) |=> (lexp_q[i] == $past(lexp_wdata)));
  end

  // Shared adder tree over the exposures.
  always_comb begin
    num_c = '0;
    den_c = '0;
    for (int i = 0; i < P; i++) begin
      num_c = num_c + SUM_W'(prod_l[i]);
      den_c = den_c + DEN_W'(w_l[i]);
    end
  end

  always_ff @(posedge clk) begin
    num_s4 <= num_c;
    den_s4 <= den_c;
    fb_s4  <= diff_l[MID];
  end

  hdrm_div #(.SUM_W(SUM_W), .DEN_W(DEN_W), .DIFF_W(DIFF_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .v_i   (vpipe[LAT-2]),
    .num_i (num_s4),
    .den_i (den_s4),
    .fb_i  (fb_s4),
    .q_o   (out_lrad)
  );

  assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 5));

  assert_idle_no_output_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##5 !out_valid);
endmodule

// File: tb/hdrm_merge_bench.sv
module hdrm_merge_bench;
  localparam int P = 3;
  localparam int PIX_W = 10;
  localparam int G_W = 16;
  localparam int ZMIN = 0;
  localparam int ZMAX = 1023;
  localparam int SEL_W = 2;

  logic clk = 0;
  logic rst = 1;
  logic lut_we = 0;
  logic [PIX_W-1:0] lut_addr = '0;
  logic signed [G_W-1:0] lut_wdata = '0;
  logic lexp_we = 0;
  logic [SEL_W-1:0] lexp_sel = '0;
  logic signed [G_W-1:0] lexp_wdata = '0;
  logic in_valid = 0;
  logic [P*PIX_W-1:0] pix_in = '0;
  logic out_valid;
  logic signed [G_W:0] out_lrad;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  longint gm [1024];
  longint le [P];

  longint exp_q [$];
  int     due_q [$];
  string  tag_q [$];

  hdrm_merge #(.P(P), .PIX_W(PIX_W), .G_W(G_W), .ZMIN(ZMIN), .ZMAX(ZMAX)) u_hdrm_merge (
    .clk(clk), .rst(rst), .lut_we(lut_we), .lut_addr(lut_addr), .lut_wdata(lut_wdata),
    .lexp_we(lexp_we), .lexp_sel(lexp_sel), .lexp_wdata(lexp_wdata),
    .in_valid(in_valid), .pix_in(pix_in), .out_valid(out_valid), .out_lrad(out_lrad)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint wt(input int z);
    if (2 * z <= ZMIN + ZMAX) return longint'(z - ZMIN);
    return longint'(ZMAX - z);
  endfunction

  function automatic longint model(input int z0, input int z1, input int z2);
    int z [P];
    longint num, den;
    z[0] = z0; z[1] = z1; z[2] = z2;
    num = 0; den = 0;
    for (int i = 0; i < P; i++) begin
      num += wt(z[i]) * (gm[z[i]] - le[i]);
      den += wt(z[i]);
    end
    if (den == 0) return gm[z[1]] - le[1];
    return num / den;
  endfunction

  task automatic check(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Output monitor: compares each result with its queued expectation and due cycle.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected out_valid", 1, 0);
      end else begin
        longint e; int d; string t;
        e = exp_q.pop_front(); d = due_q.pop_front(); t = tag_q.pop_front();
        check({"R2 latency ", t}, cyc, d);
        check(t, longint'(out_lrad), e);
      end
    end
  end

  task automatic push(input int z0, input int z1, input int z2, input string tag);
    @(negedge clk);
    in_valid = 1;
    pix_in = {PIX_W'(z2), PIX_W'(z1), PIX_W'(z0)};
    exp_q.push_back(model(z0, z1, z2));
    due_q.push_back(cyc + 5);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0;
      pix_in = {PIX_W'(k * 37 + 5), PIX_W'(k * 91 + 500), PIX_W'(k * 13 + 1000)};
    end
  endtask

  task automatic drain();
    idle(8);
    check("R2/R8 all results delivered", exp_q.size(), 0);
  endtask

  task automatic write_lut(input int a, input longint v);
    @(negedge clk);
    lut_we = 1; lut_addr = PIX_W'(a); lut_wdata = G_W'(v);
    gm[a] = v;
    @(negedge clk);
    lut_we = 0;
  endtask

  task automatic write_lexp(input int s, input longint v);
    @(negedge clk);
    lexp_we = 1; lexp_sel = SEL_W'(s); lexp_wdata = G_W'(v);
    le[s] = v;
    @(negedge clk);
    lexp_we = 0;
  endtask

  task automatic t_reset();
    in_valid = 1;
    pix_in = {10'd300, 10'd400, 10'd500};
    repeat (4) @(negedge clk);
    rst = 0;
    in_valid = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R1 out_valid low after reset", out_valid, 0);
    end
  endtask

  task automatic t_load();
    for (int a = 0; a < 1024; a++) begin
      @(negedge clk);
      lut_we = 1; lut_addr = PIX_W'(a);
      lut_wdata = G_W'(a * 24 - 12000);
      gm[a] = longint'(a * 24 - 12000);
    end
    @(negedge clk);
    lut_we = 0;
    write_lexp(0, -8000);
    write_lexp(1, 0);
    write_lexp(2, 9000);
  endtask

  task automatic t_patterns();
    push(200, 450, 700, "R4 mixed");
    idle(6);
    push(30, 60, 120, "R4 dark");
    push(900, 980, 1010, "R4 bright");
    push(100, 800, 333, "R4 spread");
    drain();
  endtask

  task automatic t_hat();
    push(511, 512, 0, "R3 midpoint pair");
    push(0, 511, 1023, "R3 single lane");
    push(1, 1022, 512, "R3 near ends");
    drain();
  endtask

  task automatic t_fallback();
    push(0, 1023, 1023, "R7 all saturated a");
    push(1023, 0, 0, "R7 all saturated b");
    push(0, 0, 0, "R7 all dark");
    drain();
  endtask

  task automatic t_stream();
    for (int k = 0; k < 24; k++)
      push((k * 97) % 1024, (k * 211 + 300) % 1024, (k * 53 + 900) % 1024, "R2/R4 stream");
    drain();
  endtask

  task automatic t_gaps();
    for (int k = 0; k < 8; k++) begin
      push((k * 61 + 40) % 1024, (k * 17 + 480) % 1024, (k * 29 + 850) % 1024, "R8 gapped");
      idle(k % 3 + 1);
    end
    drain();
  endtask

  task automatic t_reload();
    write_lexp(2, -5000);
    push(200, 450, 700, "R6 new constant");
    drain();
    write_lut(450, 20000);
    push(450, 450, 450, "R5 rewritten entry");
    push(200, 450, 700, "R5 rewritten entry mixed");
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_patterns();
    t_hat();
    t_fallback();
    t_stream();
    t_gaps();
    t_reload();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule